// File: doc/BRIEF.md
# Successive-Approximation Conversion Engine with Range Clamping

This block runs the digital half of a 12-bit successive-approximation analog-to-digital conversion. A single-cycle start request launches a binary search. Each clock cycle the engine presents a trial code on `dac_code` to an external DAC. It reads back one comparator bit, `cmp_hi`, which is high when the analog input is at or above the trial level. It then settles that bit and moves one bit down, from the most significant bit to bit 0.

Internally the search works in offset binary. The finished word is converted to two's complement by inverting its top bit. If the search ends pinned at either end of the range, the engine forces the fixed full-scale code for that end: 0x7FF when every bit resolved to 1 and the final compare still reported "above", and 0x800 when every bit resolved to 0 and the final compare still reported "below". The result is registered, is flagged by a one-cycle `done` pulse, and holds until the next conversion finishes. At 50 MHz a conversion takes 13 cycles (260 ns), which is far inside a 15 µs per-conversion budget.

Top module: `sar_conv_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `done` are 0 and `result` and `dac_code` are 0.
- R2: A `start` pulse seen while `busy` is low raises `busy` at the next clock edge. `busy` then stays high for exactly 12 cycles.
- R3: The first trial code after a start is 0x800. At every later edge during a conversion, the bit under trial is kept at 1 only if `cmp_hi` was 1. That bit is cleared otherwise, the higher bits are kept, and the next lower bit is set to 1.
- R4: The result is the settled offset-binary code with bit 11 inverted. An input at offset level 2048 gives 0x000, 2047 gives 0xFFF, 1 gives 0x801 and 1234 gives 0xCD2.
- R5: An input at or above the top trial level (offset 4095 or beyond) gives the positive full-scale code 0x7FF.
- R6: An input below the first code step (offset 0 or below) gives the negative full-scale code 0x800.
- R7: `done` is high for one cycle. It comes in the cycle in which `busy` has just fallen, and `result` already holds the new value in that cycle.
- R8: A `start` pulse that arrives while `busy` is high has no effect. The running conversion keeps its trial sequence and length, and it produces one `done`.
- R9: `result` keeps its value until the next `done`, whatever `cmp_hi` and `start` do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle conversion request |
| cmp_hi | input | 1 | Comparator: input at or above the trial level |
| dac_code | output | 12 | Trial code for the external DAC (offset binary) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: new result registered |
| result | output | 12 | Two's complement conversion result |

## Verification
The hardest cases to reach are the two clamp conditions and a start request that lands in the middle of a search. The bench drives the comparator from an integer input level, so it can place that level beyond 4095 or below 0. This pins every trial to one outcome and exercises both full-scale paths, along with the exact edge levels 0 and 4095. A second start is injected several cycles into a running conversion. A new start is also issued in the same cycle as `done`, which covers both the ignored-request case and the back-to-back relaunch.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    SAR_IDLE = 1'b0,
    SAR_RUN  = 1'b1
  } sar_state_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int WIDTH = 12,
  localparam int IW = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          launch,
  output logic          last,
  output logic [IW-1:0] idx
);
  import sar_pkg::*;

  sar_state_t st;

  assign busy   = (st == SAR_RUN);
  assign launch = !busy && start;
  assign last   = busy && (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SAR_IDLE;
      idx <= '0;
    end else begin
      case (st)
        SAR_IDLE: if (start) begin
          st  <= SAR_RUN;
          idx <= IW'(WIDTH - 1);
        end
        SAR_RUN: begin
          if (idx == '0) st <= SAR_IDLE;
          else           idx <= idx - 1'b1;
        end
        default: st <= SAR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int WIDTH = 12,
  localparam int IW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             busy,
  input  logic             last,
  input  logic [IW-1:0]    idx,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] trial
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        trial[i] <= 1'b0;
      end else if (launch) begin
        trial[i] <= (i == WIDTH - 1);
      end else if (busy) begin
        if (int'(idx) == i)
          trial[i] <= cmp_hi;
        else if (!last && int'(idx) == i + 1)
          trial[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_fmt.sv
module sar_fmt #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             last,
  input  logic             cmp_hi,
  input  logic [WIDTH-2:0] upper,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  localparam logic [WIDTH-1:0] POS_FS = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_FS = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] settled;
  logic             over, under;

  assign settled = {upper, cmp_hi};
  assign over    = (&upper) && cmp_hi;
  assign under   = !(|upper) && !cmp_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (last) begin
        if (over)       result <= POS_FS;
        else if (under) result <= NEG_FS;
        else            result <= {~settled[WIDTH-1], settled[WIDTH-2:0]};
      end
    end
  end
endmodule

// File: rtl/sar_conv_engine.sv
module sar_conv_engine #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] dac_code,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  localparam int IW = $clog2(WIDTH);

  logic          launch, last;
  logic [IW-1:0] idx;

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .launch(launch), .last(last), .idx(idx)
  );

  sar_trial #(.WIDTH(WIDTH)) u_trial (
    .clk(clk), .rst(rst), .launch(launch), .busy(busy), .last(last),
    .idx(idx), .cmp_hi(cmp_hi), .trial(dac_code)
  );

  sar_fmt #(.WIDTH(WIDTH)) u_fmt (
    .clk(clk), .rst(rst), .last(last), .cmp_hi(cmp_hi),
    .upper(dac_code[WIDTH-1:1]), .result(result), .done(done)
  );
endmodule

// File: rtl/sar_conv_engine_chk.sv
module sar_conv_engine_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [WIDTH-1:0] dac_code,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);
  localparam int CW = $clog2(WIDTH + 1) + 1;
  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy); // R2
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len == CW'(WIDTH))); // R2
  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (dac_code == {1'b1, {(WIDTH-1){1'b0}}})); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R9
endmodule

bind sar_conv_engine sar_conv_engine_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .dac_code(dac_code),
  .busy(busy), .done(done), .result(result)
);

// File: tb/sar_conv_engine_test.sv
module sar_conv_engine_test;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         cmp_hi;
  logic [W-1:0] dac_code, result;
  logic         busy, done;
  int           vin = 0;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  assign cmp_hi = (vin >= int'(dac_code));

  sar_conv_engine #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .start(start), .cmp_hi(cmp_hi),
    .dac_code(dac_code), .busy(busy), .done(done), .result(result)
  );

  // behavioural reference model
  bit m_busy = 0, m_done = 0;
  int m_acc = 0, m_bit = 0, m_trial = 0, m_res = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_acc = 0; m_bit = 0; m_trial = 0; m_res = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (vin >= m_trial) m_acc = m_acc + (1 << m_bit);
        if (m_bit == 0) begin
          m_busy = 0;
          m_done = 1;
          m_res  = m_acc ^ 2048;
          m_trial = m_acc;
        end else begin
          m_bit   = m_bit - 1;
          m_trial = m_acc + (1 << m_bit);
        end
      end else if (start) begin
        m_busy = 1; m_acc = 0; m_bit = 11; m_trial = 2048;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk(busy == m_busy, "R2 busy", int'(busy), int'(m_busy));
      chk(done == m_done, "R7 done", int'(done), int'(m_done));
      chk(int'(result) == m_res, "R4 result", int'(result), m_res);
      if (m_busy) chk(int'(dac_code) == m_trial, "R3 trial", int'(dac_code), m_trial);
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n_done);
    n_done = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) n_done++;
      if (done) break;
    end
  endtask

  task automatic convert(input int v, input int exp, input string req);
    int nd;
    vin = v;
    pulse_start();
    wait_done(nd);
    chk(nd == 1, req, nd, 1);
    chk(int'(result) == exp, req, int'(result), exp);
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nd, held;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset flags", int'({busy, done}), 0);
    chk(result == '0 && dac_code == '0, "R1 reset data", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && result == '0, "R1 after reset", int'(result), 0);

    convert(2048, 12'h000, "R4 mid");
    convert(2047, 12'hFFF, "R4 below mid");
    convert(1,    12'h801, "R4 one");
    convert(1234, 12'hCD2, "R4 generic");
    convert(4095, 12'h7FF, "R5 top edge");
    convert(5000, 12'h7FF, "R5 over range");
    convert(0,    12'h800, "R6 bottom edge");
    convert(-7,   12'h800, "R6 under range");

    // R8: start while busy is ignored
    vin = 3000;
    pulse_start();
    repeat (4) @(negedge clk);
    pulse_start();
    wait_done(nd);
    chk(nd == 1, "R8 one done", nd, 1);
    chk(int'(result) == (3000 ^ 2048), "R8 result", int'(result), 3000 ^ 2048);
    repeat (20) @(negedge clk);
    chk(busy == 0 && done == 0, "R8 no extra run", int'({busy, done}), 0);

    // R9: result holds while inputs move
    held = int'(result);
    vin = 100;
    repeat (10) @(negedge clk);
    chk(int'(result) == held, "R9 hold", int'(result), held);

    // back-to-back: new start in the done cycle
    vin = 777;
    pulse_start();
    for (int k = 0; k < 40; k++) begin
      if (done) break;
      @(negedge clk);
    end
    vin = 3333;
    pulse_start();
    chk(busy == 1, "R2 relaunch", int'(busy), 1);
    wait_done(nd);
    chk(int'(result) == (3333 ^ 2048), "R4 relaunch", int'(result), 3333 ^ 2048);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule